// File: doc/BRIEF.md
# Dual-Mode Start-Up Reset Sequencer

This block brings a signal-processing core up after its external active-low reset pin is released. While the pin is low, every downstream block is held powered down. After release, the sequencer counts an oscillator start-up interval before it lets the digital clocks run. It then opens a settle window of fixed length. During that window it watches writes aimed at a mode register address.

The first recognised code written to that address chooses how the core is cleared. A cold clear wipes everything, including the adaptive filter coefficients. A warm clear keeps the coefficients and key adaptation state. The code also chooses when the clear happens: when the window expires, or at once, which also cuts the window short. After a one-cycle clear strobe, the run enable rises and stays high until the pin falls again.

Three of the recognised codes also carry ordinary register settings. The sequencer forwards each of them to the register file as a normal write, re-addressed to the register that the code belongs to. A warm clear is only trusted after at least one cold clear has completed since power-on. Until then, a warm request is turned into a cold one.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_pin_n` is low, `pwr_on`, `clk_on`, `clear_all`, `clear_keep`, `run_en` and `fwd_wr_en` are all 0, asynchronously to the clock.
- R2: `pwr_on` rises on the first clock edge after `rst_pin_n` is released. `clk_on` rises on edge OSC_CYC+1. With no early exit, the clear strobe appears on edge OSC_CYC+WIN_CYC+1 and `run_en` rises on the edge after that.
- R3: If no recognised code arrives while the window is open, the strobe at window expiry is `clear_all`.
- R4: Writing code 0x0000 to MODE_ADDR in the window selects `clear_all` at expiry.
- R5: Writing code 0x0006 to MODE_ADDR in the window selects `clear_keep` at expiry.
- R6: Writing code 0x8000 to MODE_ADDR in the window gives `clear_all` on the edge right after the write is sampled, which ends the window early.
- R7: Writing code 0x8006 to MODE_ADDR in the window gives `clear_keep` on the edge right after the write is sampled.
- R8: Some codes are forwarded one cycle after they are sampled, with their data unchanged: 0x8000 goes to COLD_REG, and 0x0006 or 0x8006 go to WARM_REG. Code 0x0000, and any other write made before run, is not forwarded. In run, every write is passed through with its own address and data one cycle later.
- R9: A warm request (bit 15 free, low value 6) produces `clear_all` instead of `clear_keep` unless a `clear_all` strobe has occurred since `por_n` was last low. That history survives `rst_pin_n` cycles.
- R10: Only the first recognised code in a window counts. Other values, and writes to other addresses, neither select a mode nor end the window.
- R11: The clear strobe lasts exactly one cycle and `run_en` follows it. Pulling `rst_pin_n` low at any phase returns the block to the powered-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low; clears the cold-history flag |
| rst_pin_n | input | 1 | External reset pin, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| pwr_on | output | 1 | Downstream blocks powered |
| clk_on | output | 1 | Digital clocks allowed to run |
| clear_all | output | 1 | One-cycle clear of all state |
| clear_keep | output | 1 | One-cycle clear that keeps coefficients |
| run_en | output | 1 | Core may run |
| fwd_wr_en | output | 1 | Forwarded register write strobe |
| fwd_wr_addr | output | ADDR_W | Forwarded write address |
| fwd_wr_data | output | DATA_W | Forwarded write data |

## Verification
Faults in the phase state or the interval counter change the cycle on which `clk_on`, the clear strobe or `run_en` move. A cycle-accurate model compared on every clock therefore flags such a fault on the first edge where those outputs should have changed. A corrupted mode latch shows as the wrong strobe kind, or as a strobe in the wrong cycle, at the end of the same window. A lost cold-history flag shows only in the next sequence that asks for a warm clear, so the scenarios alternate power-on cycles with warm requests.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [2:0] {
      PH_OFF,
      PH_OSC,
      PH_WIN,
      PH_STB,
      PH_RUN
   } phase_t;

   localparam int unsigned IMM_BIT   = 15;
   localparam int unsigned WARM_LOW  = 6;
   localparam int unsigned CODE_BITS = 16;
endpackage

// File: rtl/rstseq_countdown.sv
module rstseq_countdown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   assert_no_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rstseq_cmd_decode.sv
module rstseq_cmd_decode
   import rstseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MODE_ADDR = 15,
   parameter int unsigned COLD_REG  = 0,
   parameter int unsigned WARM_REG  = 3
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit,
   output logic              imm,
   output logic              warm,
   output logic              fwd,
   output logic [ADDR_W-1:0] fwd_addr
);
   logic [DATA_W-1:0] rest;
   logic              addr_ok;

   always_comb begin
      rest          = wr_data;
      rest[IMM_BIT] = 1'b0;
   end

   assign addr_ok  = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
   assign warm     = (rest == DATA_W'(WARM_LOW));
   assign imm      = wr_data[IMM_BIT];
   assign hit      = addr_ok && (warm || rest == '0);
   assign fwd      = imm || warm;
   assign fwd_addr = warm ? ADDR_W'(WARM_REG) : ADDR_W'(COLD_REG);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int unsigned OSC_CYC      = 81920,
   parameter int unsigned WIN_CYC      = 8192,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned MODE_ADDR    = 15,
   parameter int unsigned COLD_REG     = 0,
   parameter int unsigned WARM_REG     = 3,
   parameter bit          PROMOTE_WARM = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwr_on,
   output logic              clk_on,
   output logic              clear_all,
   output logic              clear_keep,
   output logic              run_en,
   output logic              fwd_wr_en,
   output logic [ADDR_W-1:0] fwd_wr_addr,
   output logic [DATA_W-1:0] fwd_wr_data
);
   localparam int unsigned MAX_CYC = (OSC_CYC > WIN_CYC) ? OSC_CYC : WIN_CYC;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   initial begin
      assert (OSC_CYC >= 1) else $error("OSC_CYC must be at least 1");
      assert (WIN_CYC >= 1) else $error("WIN_CYC must be at least 1");
      assert (DATA_W >= CODE_BITS) else $error("DATA_W too narrow for codes");
      assert (MODE_ADDR < (1 << ADDR_W)) else $error("MODE_ADDR out of range");
      assert (WARM_REG < (1 << ADDR_W) && COLD_REG < (1 << ADDR_W))
         else $error("target register out of range");
   end

   phase_t            ph_q, ph_d;
   logic              t_load, t_dec, t_zero;
   logic [CNT_W-1:0]  t_val;
   logic              d_hit, d_imm, d_warm, d_fwd;
   logic [ADDR_W-1:0] d_faddr;
   logic              locked_q, lock_warm_q, stb_warm_q, cold_done_q;
   logic              take, warm_req, warm_ok;

   rstseq_countdown #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_pin_n),
      .load     (t_load),
      .load_val (t_val),
      .dec      (t_dec),
      .zero     (t_zero)
   );

   rstseq_cmd_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MODE_ADDR (MODE_ADDR),
      .COLD_REG  (COLD_REG),
      .WARM_REG  (WARM_REG)
   ) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .hit      (d_hit),
      .imm      (d_imm),
      .warm     (d_warm),
      .fwd      (d_fwd),
      .fwd_addr (d_faddr)
   );

   assign take     = (ph_q == PH_WIN) && d_hit && !locked_q;
   assign warm_req = locked_q ? lock_warm_q : (take && d_warm);

   generate
      if (PROMOTE_WARM) begin : g_promote
         assign warm_ok = warm_req && cold_done_q;
         assert_warm_needs_cold_R9 : assert property (@(posedge clk)
            disable iff (!rst_pin_n) clear_keep |-> cold_done_q);
      end else begin : g_trust
         assign warm_ok = warm_req;
      end
   endgenerate

   always_comb begin
      ph_d   = ph_q;
      t_load = 1'b0;
      t_dec  = 1'b0;
      t_val  = '0;
      unique case (ph_q)
         PH_OFF: begin
            ph_d   = PH_OSC;
            t_load = 1'b1;
            t_val  = CNT_W'(OSC_CYC - 1);
         end
         PH_OSC: begin
            if (t_zero) begin
               ph_d   = PH_WIN;
               t_load = 1'b1;
               t_val  = CNT_W'(WIN_CYC - 1);
            end else begin
               t_dec = 1'b1;
            end
         end
         PH_WIN: begin
            if ((take && d_imm) || t_zero) ph_d = PH_STB;
            else                           t_dec = 1'b1;
         end
         PH_STB:  ph_d = PH_RUN;
         PH_RUN:  ph_d = PH_RUN;
         default: ph_d = PH_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) begin
         ph_q        <= PH_OFF;
         locked_q    <= 1'b0;
         lock_warm_q <= 1'b0;
         stb_warm_q  <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (take) begin
            locked_q    <= 1'b1;
            lock_warm_q <= d_warm;
         end
         if (ph_q == PH_WIN && ph_d == PH_STB)
            stb_warm_q <= warm_ok;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cold_done_q <= 1'b0;
      else if (rst_pin_n && ph_q == PH_STB && !stb_warm_q)
         cold_done_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) begin
         fwd_wr_en   <= 1'b0;
         fwd_wr_addr <= '0;
         fwd_wr_data <= '0;
      end else begin
         fwd_wr_en   <= (ph_q == PH_RUN && wr_en) || (take && d_fwd);
         fwd_wr_addr <= (ph_q == PH_RUN) ? wr_addr : d_faddr;
         fwd_wr_data <= wr_data;
      end
   end

   assign pwr_on     = (ph_q != PH_OFF);
   assign clk_on     = (ph_q == PH_WIN) || (ph_q == PH_STB) || (ph_q == PH_RUN);
   assign clear_all  = (ph_q == PH_STB) && !stb_warm_q;
   assign clear_keep = (ph_q == PH_STB) && stb_warm_q;
   assign run_en     = (ph_q == PH_RUN);

   assert_pin_low_off_R1 : assert property (@(posedge clk) disable iff (!por_n)
      !rst_pin_n |-> (!pwr_on && !run_en && !fwd_wr_en));
   assert_strobe_excl_R11 : assert property (@(posedge clk) disable iff (!rst_pin_n)
      !(clear_all && clear_keep));
   assert_strobe_then_run_R11 : assert property (@(posedge clk) disable iff (!rst_pin_n)
      (clear_all || clear_keep) |=> (run_en && !clear_all && !clear_keep));
   assert_run_holds_R11 : assert property (@(posedge clk) disable iff (!rst_pin_n)
      run_en |=> run_en);
   assert_clk_before_run_R2 : assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(clk_on) |-> ($past(pwr_on) && !run_en));
   assert_fwd_only_late_R8 : assert property (@(posedge clk) disable iff (!rst_pin_n)
      fwd_wr_en |-> clk_on);
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
   localparam int OSC = 5;
   localparam int WIN = 8;
   localparam int AW  = 4;
   localparam int DW  = 16;
   localparam int MA  = 15;

   logic          clk = 1'b0;
   logic          por_n = 1'b1;
   logic          rst_pin_n = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          pwr_on, clk_on, clear_all, clear_keep, run_en, fwd_wr_en;
   logic [AW-1:0] fwd_wr_addr;
   logic [DW-1:0] fwd_wr_data;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    armed = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rstseq_top #(.OSC_CYC(OSC), .WIN_CYC(WIN), .ADDR_W(AW), .DATA_W(DW),
                .MODE_ADDR(MA), .COLD_REG(0), .WARM_REG(3), .PROMOTE_WARM(1'b1)) uut (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwr_on(pwr_on), .clk_on(clk_on),
      .clear_all(clear_all), .clear_keep(clear_keep), .run_en(run_en),
      .fwd_wr_en(fwd_wr_en), .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data));

   // Behavioural reference: phase 0 off, 1 osc, 2 window, 3 strobe, 4 run
   int          m_ph = 0, m_cnt = 0;
   bit          m_locked = 0, m_lwarm = 0, m_swarm = 0, m_cold = 0;
   bit          m_fen = 0;
   int          m_faddr = 0, m_fdata = 0;

   always @(posedge clk or negedge rst_pin_n or negedge por_n) begin
      if (!por_n) m_cold = 0;
      if (!rst_pin_n) begin
         m_ph = 0; m_cnt = 0; m_locked = 0; m_lwarm = 0; m_swarm = 0; m_fen = 0;
         m_faddr = 0; m_fdata = 0;
      end else begin
         int  low;
         bit  hit, imm, wrm, tk, wreq;
         low  = int'(wr_data) & 16'h7fff;
         imm  = wr_data[15];
         wrm  = (low == 6);
         hit  = wr_en && int'(wr_addr) == MA && (low == 0 || low == 6);
         tk   = (m_ph == 2) && hit && !m_locked;
         wreq = m_locked ? m_lwarm : (tk && wrm);
         m_fen = (m_ph == 4 && wr_en) || (tk && (imm || wrm));
         m_faddr = (m_ph == 4) ? int'(wr_addr) : (wrm ? 3 : 0);
         m_fdata = int'(wr_data);
         case (m_ph)
            0: begin m_ph = 1; m_cnt = OSC - 1; end
            1: if (m_cnt == 0) begin m_ph = 2; m_cnt = WIN - 1; end else m_cnt--;
            2: begin
               if ((tk && imm) || m_cnt == 0) begin
                  m_ph = 3; m_swarm = wreq && m_cold;
               end else m_cnt--;
               if (tk) begin m_locked = 1; m_lwarm = wrm; end
            end
            3: begin if (!m_swarm) m_cold = 1; m_ph = 4; end
            default: m_ph = 4;
         endcase
      end
   end

   always @(negedge clk) begin
      if (armed && !done) begin
         bit ok;
         bit e_pwr, e_clk, e_ca, e_ck, e_run;
         e_pwr = (m_ph != 0);
         e_clk = (m_ph >= 2);
         e_ca  = (m_ph == 3) && !m_swarm;
         e_ck  = (m_ph == 3) && m_swarm;
         e_run = (m_ph == 4);
         ok = (pwr_on == e_pwr) && (clk_on == e_clk) && (clear_all == e_ca) &&
              (clear_keep == e_ck) && (run_en == e_run) && (fwd_wr_en == m_fen);
         if (m_fen && ok)
            ok = (int'(fwd_wr_addr) == m_faddr) && (int'(fwd_wr_data) == m_fdata);
         n_cmp++;
         if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0t act pwr=%b clk=%b ca=%b ck=%b run=%b fen=%b fa=%0d fd=%h exp pwr=%b clk=%b ca=%b ck=%b run=%b fen=%b fa=%0d fd=%h",
               cur_req, $time, pwr_on, clk_on, clear_all, clear_keep, run_en, fwd_wr_en,
               fwd_wr_addr, fwd_wr_data, e_pwr, e_clk, e_ca, e_ck, e_run, m_fen, m_faddr,
               m_fdata[15:0]);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired act=hung exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #2;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      tick(1);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic pin_cycle();
      rst_pin_n = 1'b0;
      tick(3);
      rst_pin_n = 1'b1;
   endtask

   initial begin
      #1;
      por_n = 1'b0; rst_pin_n = 1'b0;
      armed = 1;
      cur_req = "R1 reset state";
      tick(4);
      por_n = 1'b1;
      tick(2);
      rst_pin_n = 1'b1;
      cur_req = "R2 R3 default cold at expiry";
      tick(OSC + WIN + 6);
      cur_req = "R11 pin low in run";
      pin_cycle();
      cur_req = "R5 R8 warm code 0006 at expiry";
      tick(OSC + 2);
      wr(MA, 16'h0006);
      tick(WIN + 4);
      cur_req = "R8 run pass-through";
      wr(7, 16'habcd);
      wr(MA, 16'h8006);
      tick(2);
      pin_cycle();
      cur_req = "R7 R8 immediate warm 8006";
      tick(OSC + 4);
      wr(MA, 16'h8006);
      tick(WIN + 2);
      pin_cycle();
      cur_req = "R4 R10 0000 locks cold";
      tick(OSC + 2);
      wr(MA, 16'h0000);
      wr(MA, 16'h8006);
      tick(WIN + 2);
      pin_cycle();
      cur_req = "R6 R10 R8 ignored values then 8000";
      tick(2);
      wr(MA, 16'h8000);
      tick(OSC);
      wr(MA, 16'h1234);
      wr(2, 16'h8000);
      wr(MA, 16'h0106);
      wr(MA, 16'h8000);
      wr(MA, 16'h0006);
      tick(WIN + 2);
      cur_req = "R11 pin low during oscillator wait";
      pin_cycle();
      tick(2);
      pin_cycle();
      tick(OSC + WIN + 4);
      cur_req = "R9 power cycle promotes warm";
      rst_pin_n = 1'b0; por_n = 1'b0;
      tick(3);
      por_n = 1'b1;
      tick(1);
      rst_pin_n = 1'b1;
      tick(OSC + 3);
      wr(MA, 16'h8006);
      tick(WIN + 2);
      pin_cycle();
      cur_req = "R9 warm honoured after cold";
      tick(OSC + 2);
      wr(MA, 16'h0006);
      tick(WIN + 4);
      cur_req = "R2 R6 code in last window cycle";
      pin_cycle();
      tick(OSC + WIN);
      wr(MA, 16'h8000);
      tick(4);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule